// File: doc/BRIEF.md
# Processor Status and Emulation-Bit Controller

This block holds the status byte, the carry flag and the hidden emulation bit of a 16-bit accumulator-style processor core that can fall back to an 8-bit compatibility mode. The sequencer sends it one command at a time. A command can set carry, set decimal mode, set interrupt-disable, swap carry with the emulation bit, or load the status byte from a byte pulled off the stack. The stack read itself happens outside this block and arrives on the command's data byte.

The block also tells the register file how to reshape itself. A single-cycle pulse orders the high bytes of both index registers cleared. A second single-cycle pulse, with the page value beside it, orders the stack pointer's high byte forced to page one.

Commands use a valid/ready handshake. `cmd_ready` is held high, so the block never applies back-pressure. A command is accepted on any rising edge where `cmd_valid` is high. Its effect appears on the outputs in the following cycle.

Top module: `sfc_status_ctrl`

## Requirements
- R1: After reset `status_o` is 0x34, `emu_o` is 1 and both pulse outputs are 0.
- R2: `status_o` bit layout, from bit 7 to bit 0: negative, overflow, accumulator-width M, index-width X, decimal, interrupt-disable, zero, carry.
- R3: Command codes 1, 2 and 3 set the carry (bit 0), decimal (bit 3) and interrupt-disable (bit 2) bits respectively. Each takes one cycle and leaves every other bit and `emu_o` unchanged.
- R4: Command code 4 (exchange) moves the old carry into `emu_o` and the old `emu_o` into carry, in one cycle.
- R5: When an exchange leaves the emulation bit at 1, bits M and X become 1 and `force_stk_hi_o` pulses. `stk_hi_o` carries 0x01.
- R6: After an exchange or a pull, `clr_idx_hi_o` pulses exactly when the resulting X bit is 1.
- R7: Command code 5 (pull) loads `status_o` from `cmd_byte`.
- R8: While `emu_o` is 1, bits M and X of `status_o` read 1, whatever byte was pulled.
- R9: Each pulse output is high for exactly one cycle per triggering command.
- R10: Code 0, codes 6 and 7, and any cycle with `cmd_valid` low have no effect on `status_o`, `emu_o` or the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always high; command accepted when valid |
| cmd_op | input | 3 | Command code |
| cmd_byte | input | 8 | Pulled stack byte for code 5 |
| status_o | output | 8 | Current status byte |
| emu_o | output | 1 | Emulation bit |
| clr_idx_hi_o | output | 1 | Pulse: clear index high bytes |
| force_stk_hi_o | output | 1 | Pulse: force stack high byte |
| stk_hi_o | output | 8 | Page value for the forced stack high byte |

## Verification
A wrong carry or emulation bit shows on `status_o[0]` or `emu_o` in the cycle after the command that corrupted it. A later exchange then spreads the error into the opposite bit, so a swap after every change exposes both bits. A stale or missing width flag shows as a wrong M or X bit, or as a missing or extra `clr_idx_hi_o` pulse, one cycle after the exchange or pull. A pulse that sticks shows up on the second cycle after its command.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int P_W = 8;
  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_X = 4;
  localparam int B_M = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_NOP  = 3'd0;
  localparam logic [OP_W-1:0] OP_SETC = 3'd1;
  localparam logic [OP_W-1:0] OP_SETD = 3'd2;
  localparam logic [OP_W-1:0] OP_SETI = 3'd3;
  localparam logic [OP_W-1:0] OP_XCHG = 3'd4;
  localparam logic [OP_W-1:0] OP_PULL = 3'd5;

  typedef struct packed {
    logic set_c;
    logic set_d;
    logic set_i;
    logic xchg;
    logic pull;
  } strb_t;
endpackage

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
(
  input  logic            acc_i,
  input  logic [OP_W-1:0] op_i,
  output strb_t           strb_o
);
  always_comb begin
    strb_o = '0;
    if (acc_i) begin
      case (op_i)
        OP_SETC: strb_o.set_c = 1'b1;
        OP_SETD: strb_o.set_d = 1'b1;
        OP_SETI: strb_o.set_i = 1'b1;
        OP_XCHG: strb_o.xchg  = 1'b1;
        OP_PULL: strb_o.pull  = 1'b1;
        default: strb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfc_flag_regs.sv
module sfc_flag_regs
  import sfc_pkg::*;
#(
  parameter logic [P_W-1:0] RESET_P = 8'h34,
  parameter logic           RESET_E = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strb_t          strb_i,
  input  logic [P_W-1:0] byte_i,
  output logic [P_W-1:0] p_o,
  output logic           e_o,
  output logic [P_W-1:0] p_nxt_o,
  output logic           e_nxt_o
);
  logic [P_W-1:0] p_q, p_n;
  logic           e_q, e_n;

  always_comb begin
    p_n = p_q;
    e_n = e_q;
    if (strb_i.set_c) p_n[B_C] = 1'b1;
    if (strb_i.set_d) p_n[B_D] = 1'b1;
    if (strb_i.set_i) p_n[B_I] = 1'b1;
    if (strb_i.pull)  p_n = byte_i;
    if (strb_i.xchg) begin
      e_n      = p_q[B_C];
      p_n[B_C] = e_q;
    end
    // width flags are pinned high while in compatibility mode
    if (e_n) begin
      p_n[B_M] = 1'b1;
      p_n[B_X] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= RESET_P;
      e_q <= RESET_E;
    end else begin
      p_q <= p_n;
      e_q <= e_n;
    end
  end

  assign p_o     = p_q;
  assign e_o     = e_q;
  assign p_nxt_o = p_n;
  assign e_nxt_o = e_n;
endmodule

// File: rtl/sfc_side_fx.sv
module sfc_side_fx
  import sfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  strb_t strb_i,
  input  logic  x_nxt_i,
  input  logic  e_nxt_i,
  output logic  clr_idx_o,
  output logic  force_stk_o
);
  logic clr_q, frc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
      frc_q <= 1'b0;
    end else begin
      clr_q <= (strb_i.xchg | strb_i.pull) & x_nxt_i;
      frc_q <= strb_i.xchg & e_nxt_i;
    end
  end

  assign clr_idx_o   = clr_q;
  assign force_stk_o = frc_q;
endmodule

// File: rtl/sfc_status_ctrl.sv
module sfc_status_ctrl
  import sfc_pkg::*;
#(
  parameter logic [P_W-1:0] RESET_STATUS = 8'h34,
  parameter logic           RESET_EMU    = 1'b1,
  parameter int             PAGE_W       = 8,
  parameter logic [PAGE_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [P_W-1:0]    cmd_byte,
  output logic [P_W-1:0]    status_o,
  output logic              emu_o,
  output logic              clr_idx_hi_o,
  output logic              force_stk_hi_o,
  output logic [PAGE_W-1:0] stk_hi_o
);
  strb_t          strb;
  logic [P_W-1:0] p_nxt;
  logic           e_nxt;

  assign cmd_ready = 1'b1;
  assign stk_hi_o  = STACK_PAGE;

  sfc_decode u_dec (
    .acc_i  (cmd_valid & cmd_ready),
    .op_i   (cmd_op),
    .strb_o (strb)
  );

  sfc_flag_regs #(.RESET_P(RESET_STATUS), .RESET_E(RESET_EMU)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb_i  (strb),
    .byte_i  (cmd_byte),
    .p_o     (status_o),
    .e_o     (emu_o),
    .p_nxt_o (p_nxt),
    .e_nxt_o (e_nxt)
  );

  sfc_side_fx u_fx (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_i      (strb),
    .x_nxt_i     (p_nxt[B_X]),
    .e_nxt_i     (e_nxt),
    .clr_idx_o   (clr_idx_hi_o),
    .force_stk_o (force_stk_hi_o)
  );
endmodule

// File: rtl/sfc_status_ctrl_chk.sv
module sfc_status_ctrl_chk
  import sfc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [OP_W-1:0] cmd_op,
  input logic [P_W-1:0]  status_o,
  input logic            emu_o,
  input logic            clr_idx_hi_o,
  input logic            force_stk_hi_o
);
  logic xchg_acc, pull_acc, setc_acc, idle;
  assign xchg_acc = cmd_valid && cmd_op == OP_XCHG;
  assign pull_acc = cmd_valid && cmd_op == OP_PULL;
  assign setc_acc = cmd_valid && cmd_op == OP_SETC;
  assign idle     = !cmd_valid || cmd_op == OP_NOP || cmd_op > OP_PULL;

  assert_setc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    setc_acc |=> status_o[B_C]);
  assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_acc |=> (emu_o == $past(status_o[B_C])) && (status_o[B_C] == $past(emu_o)));
  assert_enter_emu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_acc && status_o[B_C]) |=> force_stk_hi_o && status_o[B_M] && status_o[B_X]);
  assert_clr_needs_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_idx_hi_o |-> status_o[B_X]);
  assert_emu_widths_R8: assert property (@(posedge clk) disable iff (!rst_n)
    emu_o |-> status_o[B_M] && status_o[B_X]);
  assert_force_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_stk_hi_o |-> $past(xchg_acc));
  assert_clr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_idx_hi_o |-> $past(xchg_acc || pull_acc));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(status_o) && $stable(emu_o) && !clr_idx_hi_o && !force_stk_hi_o);
endmodule

bind sfc_status_ctrl sfc_status_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .status_o       (status_o),
  .emu_o          (emu_o),
  .clr_idx_hi_o   (clr_idx_hi_o),
  .force_stk_hi_o (force_stk_hi_o)
);

// File: tb/sfc_status_ctrl_bench.sv
module sfc_status_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] status_o;
  logic       emu_o;
  logic       clr_idx_hi_o;
  logic       force_stk_hi_o;
  logic [7:0] stk_hi_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sfc_status_ctrl u_sfc_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .status_o(status_o), .emu_o(emu_o),
    .clr_idx_hi_o(clr_idx_hi_o), .force_stk_hi_o(force_stk_hi_o), .stk_hi_o(stk_hi_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one command for one edge; return at the next negedge
  task automatic issue(input logic v, input logic [2:0] op, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_byte = 8'h00;
  endtask

  task automatic expect_all(input string req, input logic [7:0] st, input logic e,
                            input logic clr, input logic frc);
    chk({req, " status"}, status_o, st);
    chk({req, " emu"}, {7'd0, emu_o}, {7'd0, e});
    chk({req, " clr_idx"}, {7'd0, clr_idx_hi_o}, {7'd0, clr});
    chk({req, " force_stk"}, {7'd0, force_stk_hi_o}, {7'd0, frc});
  endtask

  task automatic t_reset;
    expect_all("R1", 8'h34, 1'b1, 1'b0, 1'b0);
    chk("R1 ready", {7'd0, cmd_ready}, 8'h01);
  endtask

  task automatic t_leave_emu;
    issue(1'b1, 3'd1, 8'h00);                    // R3 set carry
    expect_all("R3 setc", 8'h35, 1'b1, 1'b0, 1'b0);
    issue(1'b1, 3'd4, 8'h00);                    // R4 swap C=1,E=1 stays emu
    expect_all("R5 xchg stay", 8'h35, 1'b1, 1'b1, 1'b1);
    chk("R5 page", stk_hi_o, 8'h01);
    @(negedge clk);
    expect_all("R9 pulse end", 8'h35, 1'b1, 1'b0, 1'b0);
    issue(1'b1, 3'd5, 8'h00);                    // R8 pull in emu
    expect_all("R8 pull emu", 8'h30, 1'b1, 1'b1, 1'b0);
    issue(1'b1, 3'd4, 8'h00);                    // R4 C=0 -> E=0, C=1
    expect_all("R4 leave emu", 8'h31, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_pull_native;
    issue(1'b1, 3'd5, 8'h00);
    expect_all("R7 pull 00", 8'h00, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd5, 8'hC3);
    expect_all("R7 pull C3", 8'hC3, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd5, 8'h10);
    expect_all("R6 pull X", 8'h10, 1'b0, 1'b1, 1'b0);
    issue(1'b1, 3'd5, 8'h20);
    expect_all("R2 pull M only", 8'h20, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_set_flags;
    issue(1'b1, 3'd5, 8'h00);
    issue(1'b1, 3'd1, 8'hFF);
    expect_all("R3 setc", 8'h01, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd2, 8'h00);
    expect_all("R3 setd", 8'h09, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd3, 8'h00);
    expect_all("R3 seti", 8'h0D, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ignored;
    issue(1'b0, 3'd5, 8'hFF);
    expect_all("R10 invalid", 8'h0D, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd6, 8'hFF);
    expect_all("R10 code6", 8'h0D, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd7, 8'hFF);
    expect_all("R10 code7", 8'h0D, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 3'd0, 8'hFF);
    expect_all("R10 nop", 8'h0D, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_enter_emu;
    issue(1'b1, 3'd4, 8'h00);                    // C=1,E=0 -> E=1,C=0
    expect_all("R5 enter emu", 8'h3C, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    expect_all("R9 both end", 8'h3C, 1'b1, 1'b0, 1'b0);
    issue(1'b1, 3'd4, 8'h00);                    // E=1,C=0 -> E=0,C=1
    issue(1'b1, 3'd5, 8'h02);
    issue(1'b1, 3'd4, 8'h00);                    // C=0,E=0 -> no change, no pulses
    expect_all("R6 xchg native no X", 8'h02, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_leave_emu();
    t_pull_native();
    t_set_flags();
    t_ignored();
    t_enter_emu();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule